// File: doc/BRIEF.md
# Serial Configuration Register with Line-Deferred Apply

This block receives a 32-bit configuration word over a three-wire serial link (data, shift clock, strobe) for a sensor timing generator. Bits are shifted into a shadow register on rising shift-clock edges while the strobe is low. A rising strobe copies the shadow word into a holding latch. The fields are then decoded onto dedicated outputs.

Most fields reach the active configuration only at the first rising edge of the horizontal reference during which the readout-active qualifier is high. A single-cycle apply pulse accompanies each such update, so downstream pulse logic can switch all fields together. The power-save bit is the exception: it takes effect at the strobe. While it is set, every other field reads zero. An asynchronous active-low all-clear empties the shadow register, the latch and the active configuration. All serial and line inputs are brought into the system clock domain through synchronisers. The shift clock must therefore run at no more than a quarter of the system clock rate.

Top module: `sercfg_top`

## Requirements
- R1: Bits are taken from `ser_dat` on each synchronised rising edge of `ser_clk`. The first bit sent lands in bit 0 of the word and the 32nd bit sent lands in bit 31.
- R2: A rising edge of `ser_stb` captures the current shadow word into the holding latch. The latch changes at no other time.
- R3: Rising edges of `ser_clk` that occur while `ser_stb` is high leave the shadow register unchanged.
- R4: Word bit 12 (power-save) appears on `pwr_save` after a strobe rising edge, with no horizontal-line event needed. It changes at no other time except all-clear.
- R5: While `pwr_save` is high, every other configuration output is zero.
- R6: All fields other than power-save keep their value until a rising edge of `hd` seen while `rd_act` is high. A rising edge of `hd` with `rd_act` low changes nothing.
- R7: `apply_pulse` is high for exactly one clock cycle per qualifying horizontal edge.
- R8: Field positions are as follows. Bits 6:0 are `shutter_step`, bits 9:7 are `exp_fields`, bit 10 is `still_mode`, bit 11 is `integ_mode`, bit 13 is `samp_pol`, bit 14 is `mode_sel`, bit 15 is `blk_clamp` and bits 31:16 are `phase_ctl`.
- R9: Driving `clr_n` low sets all outputs to zero and also clears the shadow register and the holding latch. A later strobe and qualifying line with no new bits shifted therefore yield all zeros.
- R10: When power-save is released by a new strobe, the other fields stay zero until the next qualifying line applies the latched word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| clr_n | input | 1 | Asynchronous active-low all-clear |
| ser_dat | input | 1 | Serial data |
| ser_clk | input | 1 | Serial shift clock |
| ser_stb | input | 1 | Serial latch strobe |
| hd | input | 1 | Horizontal line reference |
| rd_act | input | 1 | Readout-active line qualifier |
| shutter_step | output | 7 | High-speed shutter step |
| exp_fields | output | 3 | Number of exposed fields |
| still_mode | output | 1 | 1 = still, 0 = monitoring |
| integ_mode | output | 1 | Integration mode |
| pwr_save | output | 1 | Power-save, immediate |
| samp_pol | output | 1 | Sampling pulse polarity |
| mode_sel | output | 1 | Mode select |
| blk_clamp | output | 1 | Black-clamp pulse control |
| phase_ctl | output | 16 | Phase control fields |
| apply_pulse | output | 1 | One-cycle marker of a deferred update |

## Verification
The bench builds the block with its default 32-bit frame and two synchroniser stages. At this size a walking-one sweep over every bit position is affordable. That sweep reaches each field boundary and, at bit 12, the power-save path with its forced-zero behaviour. Pseudo-random frames from an LFSR are added on top of the sweep. Separate sequences cover strobe-high shift edges, unqualified lines, release from power-save and all-clear, using a bit-level model of the latch and the active word.

// File: rtl/sercfg_pkg.sv
// Shared widths, field positions and the configuration word layout.
package sercfg_pkg;
    localparam int FRAME_W = 32;
    localparam int PWR_BIT = 12;

    // Packed so that bit n of the serial word maps to bit n of the struct.
    typedef struct packed {
        logic [15:0] phase;
        logic        blk_clamp;
        logic        mode_sel;
        logic        samp_pol;
        logic        pwr;
        logic        integ;
        logic        still;
        logic [2:0]  exp_f;
        logic [6:0]  shut;
    } cfg_t;
endpackage

// File: rtl/sercfg_sync.sv
// Multi-bit level synchroniser: each bit passes through STAGES flops.
// Assumes the inputs are independent levels held longer than STAGES clocks.
module sercfg_sync #(
    parameter int W      = 4,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    generate
        for (genvar b = 0; b < W; b++) begin : g_bit
            logic [STAGES-1:0] chain;
            // Shift the bit along its own chain of flops.
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain <= '0;
                else        chain <= {chain[STAGES-2:0], d[b]};
            end
            assign q[b] = chain[STAGES-1];
        end
    endgenerate
endmodule

// File: rtl/sercfg_shift.sv
// Shadow shift register and holding latch.
// Takes synchronised data, shift clock and strobe levels. Shifts LSB-first
// on shift-clock rises while the strobe is low, and latches on strobe rises.
module sercfg_shift #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         dat_s,
    input  logic         sclk_s,
    input  logic         stb_s,
    output logic [W-1:0] hold,
    output logic         cap_pulse
);
    logic         sclk_d, stb_d;
    logic [W-1:0] shreg;
    logic         sclk_rise, stb_rise;

    assign sclk_rise = sclk_s & ~sclk_d;
    assign stb_rise  = stb_s & ~stb_d;

    // Delay the synchronised levels for edge detection.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_d <= 1'b0;
            stb_d  <= 1'b0;
        end else begin
            sclk_d <= sclk_s;
            stb_d  <= stb_s;
        end
    end

    // Shift in one bit per shift-clock rise, only while the strobe is low.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                   shreg <= '0;
        else if (sclk_rise && !stb_s) shreg <= {dat_s, shreg[W-1:1]};
    end

    // Capture the shadow word on a strobe rise; flag it one cycle later.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold      <= '0;
            cap_pulse <= 1'b0;
        end else begin
            cap_pulse <= stb_rise;
            if (stb_rise) hold <= shreg;
        end
    end

    AST_SHIFT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        stb_s |=> $stable(shreg)); // R3
    AST_HOLD_ONLY_ON_STB: assert property (@(posedge clk) disable iff (!rst_n)
        !stb_rise |=> $stable(hold)); // R2
endmodule

// File: rtl/sercfg_apply.sv
// Active configuration. Power-save follows the latch at each capture.
// Other fields load from the latch on a horizontal edge qualified by
// readout-active, and are held at zero while power-save is set.
module sercfg_apply #(
    parameter int W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [W-1:0]        hold,
    input  logic                cap_pulse,
    input  logic                hd_s,
    input  logic                act_s,
    output sercfg_pkg::cfg_t    cfg,
    output logic                apply_pulse
);
    import sercfg_pkg::*;

    logic       hd_d, apply_now, pwr_q;
    logic [W-1:0] act_q, pwr_mask;

    assign apply_now = hd_s & ~hd_d & act_s;
    assign pwr_mask  = W'(1) << PWR_BIT;

    // Edge-detect the horizontal reference and mark applies.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hd_d        <= 1'b0;
            apply_pulse <= 1'b0;
        end else begin
            hd_d        <= hd_s;
            apply_pulse <= apply_now;
        end
    end

    // Power-save tracks the latch immediately on each capture.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         pwr_q <= 1'b0;
        else if (cap_pulse) pwr_q <= hold[PWR_BIT];
    end

    // Active fields: zero under power-save, else load on a qualifying line.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         act_q <= '0;
        else if (pwr_q)     act_q <= '0;
        else if (apply_now) act_q <= hold & ~pwr_mask;
    end

    // Merge power-save into its bit position and present the struct.
    always_comb begin
        cfg     = cfg_t'(act_q);
        cfg.pwr = pwr_q;
    end

    AST_PWR_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_q |=> (act_q == '0)); // R5
    AST_ACT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (!apply_now && !pwr_q) |=> $stable(act_q)); // R6
    AST_PWR_ONLY_ON_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        !cap_pulse |=> $stable(pwr_q)); // R4
    AST_APPLY_ONESHOT: assert property (@(posedge clk) disable iff (!rst_n)
        apply_pulse |=> !apply_pulse); // R7
endmodule

// File: rtl/sercfg_top.sv
// Serial configuration register top level.
// Assumes the shift clock runs at most a quarter of clk.
// clr_n asserts asynchronously and is released in step with clk.
module sercfg_top #(
    parameter int SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        clr_n,
    input  logic        ser_dat,
    input  logic        ser_clk,
    input  logic        ser_stb,
    input  logic        hd,
    input  logic        rd_act,
    output logic [6:0]  shutter_step,
    output logic [2:0]  exp_fields,
    output logic        still_mode,
    output logic        integ_mode,
    output logic        pwr_save,
    output logic        samp_pol,
    output logic        mode_sel,
    output logic        blk_clamp,
    output logic [15:0] phase_ctl,
    output logic        apply_pulse
);
    import sercfg_pkg::*;

    localparam int NSYNC = 5;

    logic [1:0]       rst_pipe;
    logic             rst_n;
    logic [NSYNC-1:0] sync_q;
    logic [FRAME_W-1:0] hold;
    logic             cap_pulse;
    cfg_t             cfg;

    // Reset synchroniser: immediate assert, release after two clocks.
    always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n) rst_pipe <= 2'b00;
        else        rst_pipe <= {rst_pipe[0], 1'b1};
    end
    assign rst_n = rst_pipe[1];

    sercfg_sync #(.W(NSYNC), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({rd_act, hd, ser_stb, ser_clk, ser_dat}),
        .q     (sync_q)
    );

    sercfg_shift #(.W(FRAME_W)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .dat_s     (sync_q[0]),
        .sclk_s    (sync_q[1]),
        .stb_s     (sync_q[2]),
        .hold      (hold),
        .cap_pulse (cap_pulse)
    );

    sercfg_apply #(.W(FRAME_W)) u_apply (
        .clk         (clk),
        .rst_n       (rst_n),
        .hold        (hold),
        .cap_pulse   (cap_pulse),
        .hd_s        (sync_q[3]),
        .act_s       (sync_q[4]),
        .cfg         (cfg),
        .apply_pulse (apply_pulse)
    );

    assign shutter_step = cfg.shut;
    assign exp_fields   = cfg.exp_f;
    assign still_mode   = cfg.still;
    assign integ_mode   = cfg.integ;
    assign pwr_save     = cfg.pwr;
    assign samp_pol     = cfg.samp_pol;
    assign mode_sel     = cfg.mode_sel;
    assign blk_clamp    = cfg.blk_clamp;
    assign phase_ctl    = cfg.phase;
endmodule

// File: tb/sercfg_top_tb.sv
module sercfg_top_tb;
    logic clk = 0, clr_n = 0, ser_dat = 0, ser_clk = 0, ser_stb = 0, hd = 0, rd_act = 0;
    logic [6:0] shutter_step; logic [2:0] exp_fields;
    logic still_mode, integ_mode, pwr_save, samp_pol, mode_sel, blk_clamp, apply_pulse;
    logic [15:0] phase_ctl;
    int checks = 0, errors = 0, apply_cnt = 0;
    logic done = 0;
    logic [31:0] m_act = 0;   // model of active fields (bit 12 unused)
    logic        m_pwr = 0;
    logic [31:0] m_shadow = 0, m_hold = 0;

    always #5 clk = ~clk;

    sercfg_top u_dut (.clk(clk), .clr_n(clr_n), .ser_dat(ser_dat), .ser_clk(ser_clk),
        .ser_stb(ser_stb), .hd(hd), .rd_act(rd_act), .shutter_step(shutter_step),
        .exp_fields(exp_fields), .still_mode(still_mode), .integ_mode(integ_mode),
        .pwr_save(pwr_save), .samp_pol(samp_pol), .mode_sel(mode_sel), .blk_clamp(blk_clamp),
        .phase_ctl(phase_ctl), .apply_pulse(apply_pulse));

    always @(negedge clk) if (apply_pulse) apply_cnt++;

    function automatic logic [31:0] got_word();
        return {phase_ctl, blk_clamp, mode_sel, samp_pol, pwr_save, integ_mode,
                still_mode, exp_fields, shutter_step};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] model_out();
        logic [31:0] v = m_pwr ? 32'h0 : (m_act & ~32'h1000);
        v[12] = m_pwr;
        return v;
    endfunction

    task automatic shift_bit(input logic b);
        ser_dat = b; ser_clk = 0; repeat (3) @(negedge clk);
        ser_clk = 1; repeat (3) @(negedge clk);
        ser_clk = 0; repeat (2) @(negedge clk);
        if (!ser_stb) m_shadow = {b, m_shadow[31:1]};
    endtask

    task automatic send(input logic [31:0] w);
        for (int i = 0; i < 32; i++) shift_bit(w[i]);
    endtask

    task automatic strobe();
        ser_stb = 1; repeat (5) @(negedge clk);
        m_hold = m_shadow; m_pwr = m_hold[12];
        if (m_pwr) m_act = 0;
        ser_stb = 0; repeat (4) @(negedge clk);
    endtask

    task automatic line(input logic qual);
        apply_cnt = 0; rd_act = qual;
        repeat (3) @(negedge clk);
        hd = 1; repeat (5) @(negedge clk);
        hd = 0; repeat (4) @(negedge clk);
        rd_act = 0; repeat (3) @(negedge clk);
        if (qual && !m_pwr) m_act = m_hold;
    endtask

    task automatic frame_cycle(input logic [31:0] w, input string tag);
        send(w);
        strobe();
        check({tag, " R4 pwr at strobe"}, {31'h0, pwr_save}, {31'h0, w[12]});
        check({tag, " R5/R6/R10 held after strobe"}, got_word(), model_out());
        line(1'b0);
        check({tag, " R6 unqualified line"}, got_word(), model_out());
        check({tag, " R6 no pulse unqualified"}, apply_cnt, 0);
        line(1'b1);
        check({tag, " R7 one pulse"}, apply_cnt, 1);
        check({tag, " R1/R8 applied"}, got_word(), model_out());
    endtask

    initial begin
        logic [31:0] lfsr = 32'hACE1_2468;
        repeat (4) @(negedge clk);
        clr_n = 1; repeat (4) @(negedge clk);
        check("R9 reset state", got_word(), 32'h0);
        check("R9 reset pulse", {31'h0, apply_pulse}, 32'h0);
        // Walking one over every bit: each field boundary and power-save.
        for (int b = 0; b < 32; b++) frame_cycle(32'h1 << b, "walk");
        // Pseudo-random frames.
        for (int k = 0; k < 12; k++) begin
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            frame_cycle(lfsr, "lfsr");
        end
        // R3: shift edges during a high strobe are ignored.
        send(32'h1234_A5C3);
        ser_stb = 1; repeat (4) @(negedge clk);
        for (int i = 0; i < 5; i++) shift_bit(1'b1);
        ser_stb = 0; repeat (4) @(negedge clk);
        strobe(); line(1'b1);
        check("R3 strobe-high shifts ignored", got_word(), 32'h1234_A5C3 & ~32'h1000);
        // R10: power-save on, then released; fields stay zero until a line.
        send(32'hFFFF_FFFF); strobe();
        check("R5 pwr forces zero", got_word(), 32'h0000_1000);
        send(32'h0F0F_E0F0); strobe();
        check("R10 zero after release", got_word(), 32'h0);
        line(1'b1);
        check("R10 applied after release", got_word(), 32'h0F0F_E0F0);
        // R9: all-clear empties output, shadow and latch.
        send(32'hDEAD_BEEF); strobe();
        clr_n = 0; repeat (3) @(negedge clk);
        check("R9 clear outputs", got_word(), 32'h0);
        clr_n = 1; repeat (4) @(negedge clk);
        m_shadow = 0; m_hold = 0; m_act = 0; m_pwr = 0;
        strobe(); line(1'b1);
        check("R9 shadow and latch cleared", got_word(), 32'h0);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule